// File: doc/BRIEF.md
# Error-Correcting Single-Clock FIFO

This block is a first-in first-out buffer for a column read-out data path. Every word written is stored together with Hamming check bits and one overall parity bit. On the way out, the stored word is checked. A single flipped bit anywhere in the stored entry is repaired. Two flipped bits are reported but not repaired. Each read result carries a flag that tells which of these cases occurred.

The buffer holds 32 entries. Because that depth is a power of two, each pointer carries one extra wrap bit and rolls over on its own, with no compare-and-reset logic. The read and write pointers and the two sticky error flags are kept in three copies each, with majority voting, so that an upset in one copy of a control register does not disturb the buffer.

For self-test, the write port has a flip mask. The mask is XORed into the encoded entry as it is stored, which lets a test create one-bit and two-bit faults in chosen entries. When the mask is zero, the block stores the clean codeword.

Top module: `sdfifo_secded`

## Requirements
- R1: While reset is low at a clock edge, and after that edge, `empty`=1, `full`=0, `overflow`=0, `underflow`=0, `rd_valid`=0, `err_single`=0 and `err_double`=0.
- R2: Accepted words are read out in the order they were written. A read accepted at an edge (`rd_en`=1 with `empty`=0) drives `rd_valid`=1 and the word on `rd_data` after that same edge. With no accepted read, `rd_valid` is 0 after the edge.
- R3: `empty` drops after the first accepted write. `full` rises once 32 words are held. `full` and `empty` are never high together.
- R4: A write while `full`=1 is dropped and does not change the stored contents. It sets `overflow`, which stays 1 until reset.
- R5: A read while `empty`=1 is ignored, so `rd_valid` stays 0. It sets `underflow`, which stays 1 until reset.
- R6: Each entry is 39 bits: the 32-bit word, 6 Hamming check bits and 1 overall parity bit. If exactly one of the 39 bits of an entry is flipped (flip-mask bit i inverts stored bit i, for i in 0..38), the read returns the original word with `err_single`=1 and `err_double`=0.
- R7: If exactly two bits of an entry are flipped, the read gives `err_double`=1 and `err_single`=0.
- R8: A read of an unflipped entry gives `err_single`=0 and `err_double`=0. Both flags are 0 whenever `rd_valid` is 0.
- R9: The pointers wrap past 32 entries with no loss of order or data, under any mix of reads, writes and simultaneous read-and-write. When a read and a write occur together, `full` and `empty` are judged on the state before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | 32 | Word to store |
| wr_flip | input | 39 | Self-test mask XORed into the stored entry; zero for normal use |
| full | output | 1 | Buffer holds 32 words |
| rd_en | input | 1 | Read request |
| rd_data | output | 32 | Corrected word, registered |
| rd_valid | output | 1 | `rd_data` and flags belong to a read accepted at the last edge |
| empty | output | 1 | Buffer holds no word |
| err_single | output | 1 | Last read repaired a one-bit fault |
| err_double | output | 1 | Last read found an uncorrectable two-bit fault |
| overflow | output | 1 | Sticky: a write was attempted while full |
| underflow | output | 1 | Sticky: a read was attempted while empty |

## Verification
Every result of this block is due one clock edge after the stimulus that causes it. `full` and `empty` follow the pointer registers. `rd_data`, `rd_valid` and both error flags are registered from the read decision. The sticky flags come out of their voted registers. The bench drives a stimulus at a falling edge and lets one rising edge pass. It then compares every output at the next falling edge against a queue model. The model updated its expectations at the moment it drove that stimulus, using the pre-edge fill level, just as the design does.

// File: rtl/sdfifo_pkg.sv
// Package: shared helpers and types for the error-correcting FIFO.
// Assumes: data widths of at least 4 bits.
package sdfifo_pkg;

    // Number of Hamming check bits p with 2**p >= data + p + 1.
    function automatic int check_bits(input int dw);
        int p;
        p = 1;
        while ((1 << p) < (dw + p + 1)) p++;
        return p;
    endfunction

    // Outcome of checking one stored entry.
    typedef struct packed {
        logic single;
        logic dbl;
    } ecc_flags_t;

endpackage

// File: rtl/sdfifo_enc.sv
// Module: builds a 39-bit (default) SEC-DED codeword from a data word.
// Layout: bit 0 is overall parity, bits 1..N follow Hamming positions with
// check bits at power-of-two positions and data bits filling the others in
// ascending order. Assumes: purely combinational, no state.
module sdfifo_enc #(
    parameter int DATA_W = 32,
    localparam int CHK_W = sdfifo_pkg::check_bits(DATA_W),
    localparam int HAM_N = DATA_W + CHK_W
) (
    input  logic [DATA_W-1:0] data,
    output logic [HAM_N:0]    cw
);

    // Scatter data bits, then compute each check bit and the overall parity.
    always_comb begin
        int k;
        logic par;
        cw = '0;
        k  = 0;
        for (int j = 1; j <= HAM_N; j++) begin
            if ((j & (j - 1)) != 0) begin
                cw[j] = data[k];
                k++;
            end
        end
        for (int i = 0; i < CHK_W; i++) begin
            par = 1'b0;
            for (int j = 1; j <= HAM_N; j++) begin
                if (((j >> i) & 1) != 0) par = par ^ cw[j];
            end
            cw[1 << i] = par;
        end
        cw[0] = ^cw[HAM_N:1];
    end

endmodule

// File: rtl/sdfifo_dec.sv
// Module: checks a SEC-DED codeword, repairs one flipped bit and flags two.
// Assumes: layout produced by sdfifo_enc; purely combinational.
module sdfifo_dec
    import sdfifo_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CHK_W = check_bits(DATA_W),
    localparam int HAM_N = DATA_W + CHK_W
) (
    input  logic [HAM_N:0]    cw,
    output logic [DATA_W-1:0] data,
    output ecc_flags_t        flags
);

    logic [CHK_W-1:0] syn;
    logic             par_bad;
    logic [HAM_N:0]   fixed;

    // Syndrome is the XOR of the positions of all set Hamming bits.
    always_comb begin
        syn = '0;
        for (int j = 1; j <= HAM_N; j++) begin
            if (cw[j]) syn = syn ^ CHK_W'(j);
        end
        par_bad = ^cw;
    end

    // Classify: odd parity means one flip (at syn, or the parity bit itself).
    always_comb begin
        flags.single = par_bad && (int'(syn) <= HAM_N);
        flags.dbl    = (!par_bad && (syn != '0)) || (par_bad && (int'(syn) > HAM_N));
    end

    // Invert the flipped bit and gather the data positions back.
    always_comb begin
        int k;
        fixed = cw;
        if (flags.single && (syn != '0)) fixed[syn] = ~cw[syn];
        data = '0;
        k    = 0;
        for (int j = 1; j <= HAM_N; j++) begin
            if ((j & (j - 1)) != 0) begin
                data[k] = fixed[j];
                k++;
            end
        end
    end

    // R7: the decoder never reports both outcomes at once.
    always_comb begin
        a_flags_excl_r7: assert (!(flags.single && flags.dbl));
    end

endmodule

// File: rtl/sdfifo_tmr_reg.sv
// Module: register kept in three copies with a bitwise majority vote.
// Assumes: d is written every cycle, so a copy hit by an upset is rewritten
// from the voted value at the next edge. Synchronous active-low reset.
module sdfifo_tmr_reg #(
    parameter int           W       = 6,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] copy_q [3];

    // Load all three copies together.
    always_ff @(posedge clk) begin
        for (int g = 0; g < 3; g++) begin
            if (!rst_n) copy_q[g] <= RST_VAL;
            else        copy_q[g] <= d;
        end
    end

    // Two-of-three vote per bit.
    assign q = (copy_q[0] & copy_q[1]) | (copy_q[0] & copy_q[2]) | (copy_q[1] & copy_q[2]);

    // R9: with no upset, the voted value is the value loaded one edge before.
    p_vote_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (q == $past(d)));

endmodule

// File: rtl/sdfifo_store.sv
// Module: entry array with one write port and an asynchronous read port.
// Assumes: contents are not reset; the control logic never reads an entry
// that was not written since reset.
module sdfifo_store #(
    parameter int DEPTH = 32,
    parameter int W     = 39,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem_q [DEPTH];

    // Store one entry per accepted write.
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sdfifo_secded.sv
// Module: 32-deep single-clock FIFO whose entries carry SEC-DED check bits.
// Pointers carry one wrap bit; full when index bits match and wrap bits
// differ, empty when all bits match. Pointers and sticky flags are triplicated.
// Read results are registered and appear one edge after an accepted read.
// Assumes: single clock, synchronous active-low reset, DEPTH a power of two.
module sdfifo_secded
    import sdfifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int CW_W  = DATA_W + check_bits(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CW_W-1:0]   wr_flip,
    output logic              full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty,
    output logic              err_single,
    output logic              err_double,
    output logic              overflow,
    output logic              underflow
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0]     wptr, rptr, wptr_d, rptr_d;
    logic [1:0]        sticky, sticky_d;
    logic              wr_ok, rd_ok;
    logic [CW_W-1:0]   enc_cw, rd_cw;
    logic [DATA_W-1:0] dec_data;
    ecc_flags_t        dec_flags;

    // Status from the voted pointers.
    always_comb begin
        empty = (wptr == rptr);
        full  = (wptr[AW-1:0] == rptr[AW-1:0]) && (wptr[AW] != rptr[AW]);
        wr_ok = wr_en && !full;
        rd_ok = rd_en && !empty;
    end

    // Next pointer and sticky-flag values.
    always_comb begin
        wptr_d   = wr_ok ? wptr + PW'(1) : wptr;
        rptr_d   = rd_ok ? rptr + PW'(1) : rptr;
        sticky_d = {sticky[1] | (rd_en & empty), sticky[0] | (wr_en & full)};
    end

    sdfifo_tmr_reg #(.W(PW), .RST_VAL('0)) u_wptr (
        .clk(clk), .rst_n(rst_n), .d(wptr_d), .q(wptr));
    sdfifo_tmr_reg #(.W(PW), .RST_VAL('0)) u_rptr (
        .clk(clk), .rst_n(rst_n), .d(rptr_d), .q(rptr));
    sdfifo_tmr_reg #(.W(2), .RST_VAL('0)) u_sticky (
        .clk(clk), .rst_n(rst_n), .d(sticky_d), .q(sticky));

    assign overflow  = sticky[0];
    assign underflow = sticky[1];

    sdfifo_enc #(.DATA_W(DATA_W)) u_enc (.data(wr_data), .cw(enc_cw));

    sdfifo_store #(.DEPTH(DEPTH), .W(CW_W)) u_store (
        .clk  (clk),
        .we   (wr_ok),
        .waddr(wptr[AW-1:0]),
        .wdata(enc_cw ^ wr_flip),
        .raddr(rptr[AW-1:0]),
        .rdata(rd_cw)
    );

    sdfifo_dec #(.DATA_W(DATA_W)) u_dec (.cw(rd_cw), .data(dec_data), .flags(dec_flags));

    // Register the corrected word and its flags for an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            err_single <= 1'b0;
            err_double <= 1'b0;
            rd_data    <= '0;
        end else begin
            rd_valid   <= rd_ok;
            err_single <= rd_ok && dec_flags.single;
            err_double <= rd_ok && dec_flags.dbl;
            if (rd_ok) rd_data <= dec_data;
        end
    end

    // R3: never full and empty at once.
    p_full_empty_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    // R3: fill level never exceeds the depth.
    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr - rptr) <= PW'(DEPTH));
    // R4: a write into a full buffer raises overflow, and it stays raised.
    p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> overflow);
    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R5: a read from an empty buffer raises underflow, and it stays raised.
    p_udf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> underflow);
    p_udf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);
    // R2: a valid result follows only an accepted read.
    p_valid_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en && !empty));
    // R8: error flags only accompany a valid result.
    p_flags_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_single || err_double) |-> rd_valid);
    // R7: the two error outcomes exclude each other.
    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_single && err_double));

endmodule

// File: tb/sdfifo_secded_bench.sv
// Bench: directed corner cases plus seeded random traffic, checked against a
// queue model that records each word and how many bits were flipped in it.
module sdfifo_secded_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;
    localparam int CW_W       = 39;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en, rd_en;
    logic [31:0]       wr_data;
    logic [CW_W-1:0]   wr_flip;
    logic              full, empty, rd_valid, err_single, err_double, overflow, underflow;
    logic [31:0]       rd_data;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // Model state.
    logic [31:0] m_data [DEPTH];
    int          m_flips[DEPTH];
    int m_head, m_tail, m_count;
    logic        e_valid, e_single, e_double, e_ovf, e_udf;
    logic [31:0] e_data;
    bit          wrap_phase;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdfifo_secded u_sdfifo_secded (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .wr_flip(wr_flip), .full(full),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty),
        .err_single(err_single), .err_double(err_double),
        .overflow(overflow), .underflow(underflow)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Compare all outputs with the model at a falling edge.
    task automatic check_outputs();
        chk("R3 full", 64'(full), 64'(m_count == DEPTH));
        chk("R3 empty", 64'(empty), 64'(m_count == 0));
        chk("R4 overflow", 64'(overflow), 64'(e_ovf));
        chk("R5 underflow", 64'(underflow), 64'(e_udf));
        chk("R2 rd_valid", 64'(rd_valid), 64'(e_valid));
        if (e_single)      chk("R6 err_single", 64'({err_single, err_double}), 64'(2'b10));
        else if (e_double) chk("R7 err_double", 64'({err_single, err_double}), 64'(2'b01));
        else               chk("R8 no flags", 64'({err_single, err_double}), 64'(2'b00));
        if (e_valid && !e_double) begin
            if (e_single)        chk("R6 corrected data", 64'(rd_data), 64'(e_data));
            else if (wrap_phase) chk("R9 data", 64'(rd_data), 64'(e_data));
            else                 chk("R2 data", 64'(rd_data), 64'(e_data));
        end
    endtask

    // One cycle: check, drive, predict, advance to the next falling edge.
    task automatic cycle(input logic w, input logic [31:0] d, input logic [CW_W-1:0] m, input logic r);
        bit acc_w, acc_r;
        check_outputs();
        wr_en = w; wr_data = d; wr_flip = m; rd_en = r;
        acc_r = r && (m_count > 0);
        acc_w = w && (m_count < DEPTH);
        if (w && m_count == DEPTH) e_ovf = 1'b1;
        if (r && m_count == 0)     e_udf = 1'b1;
        e_valid = acc_r; e_single = 1'b0; e_double = 1'b0;
        if (acc_r) begin
            e_data   = m_data[m_head];
            e_single = (m_flips[m_head] == 1);
            e_double = (m_flips[m_head] == 2);
            m_head   = (m_head + 1) % DEPTH;
        end
        if (acc_w) begin
            m_data[m_tail]  = d;
            m_flips[m_tail] = $countones(m);
            m_tail = (m_tail + 1) % DEPTH;
        end
        m_count = m_count + int'(acc_w) - int'(acc_r);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0; wr_flip = '0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_head = 0; m_tail = 0; m_count = 0;
        e_valid = 0; e_single = 0; e_double = 0; e_ovf = 0; e_udf = 0; e_data = '0;
        chk("R1 empty", 64'(empty), 64'(1));
        chk("R1 full", 64'(full), 64'(0));
        chk("R1 sticky", 64'({overflow, underflow}), 64'(0));
        chk("R1 read outputs", 64'({rd_valid, err_single, err_double}), 64'(0));
    endtask

    function automatic logic [CW_W-1:0] two_bits(input int a, input int b);
        return (CW_W'(1) << a) | (CW_W'(1) << b);
    endfunction

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20081209);
        wrap_phase = 0;
        do_reset();
        // R3/R4: fill to the limit, then push once more.
        for (int i = 0; i < DEPTH; i++) cycle(1'b1, 32'hA500_0000 + 32'(i), '0, 1'b0);
        cycle(1'b1, 32'hDEAD_BEEF, '0, 1'b0);
        // R9: read and write together while full: write dropped.
        cycle(1'b1, 32'h1234_5678, '0, 1'b1);
        // R2: drain in order, then R5: read once more while empty.
        for (int i = 0; i < DEPTH; i++) cycle(1'b0, '0, '0, 1'b1);
        cycle(1'b0, '0, '0, 1'b1);
        // R9: read and write together while empty: read ignored.
        cycle(1'b1, 32'h0BAD_F00D, '0, 1'b1);
        cycle(1'b0, '0, '0, 1'b1);
        cycle(1'b0, '0, '0, 1'b0);
        do_reset();
        // R6: one flip at every position of the entry.
        for (int b = 0; b < CW_W; b++) begin
            cycle(1'b1, $urandom, CW_W'(1) << b, 1'b0);
            cycle(1'b0, '0, '0, 1'b1);
        end
        // R7: pairs of flips, including parity-bit pairs.
        cycle(1'b1, 32'hFFFF_FFFF, two_bits(0, 1), 1'b0);
        cycle(1'b1, 32'h0000_0000, two_bits(3, 5), 1'b0);
        cycle(1'b1, 32'h5A5A_5A5A, two_bits(37, 38), 1'b0);
        cycle(1'b1, 32'h0F0F_0F0F, two_bits(0, 20), 1'b0);
        for (int i = 0; i < 4; i++) cycle(1'b0, '0, '0, 1'b1);
        cycle(1'b0, '0, '0, 1'b0);
        do_reset();
        // R9: seeded random traffic over many wraps.
        wrap_phase = 1;
        for (int n = 0; n < 4000; n++) begin
            int sel, a, b;
            logic [CW_W-1:0] m;
            sel = $urandom % 10;
            m = '0;
            if (sel == 0) m = CW_W'(1) << ($urandom % CW_W);
            else if (sel == 1) begin
                a = $urandom % CW_W;
                b = (a + 1 + ($urandom % (CW_W - 1))) % CW_W;
                m = two_bits(a, b);
            end
            cycle(1'($urandom % 100 < 55), $urandom, m, 1'($urandom % 100 < 50));
        end
        for (int i = 0; i < DEPTH + 1; i++) cycle(1'b0, '0, '0, 1'b1);
        check_outputs();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule